// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table held in memory. When it is idle and `start_i` is pulsed, it captures the virtual address, the requested access kind and the frame number of the page directory. It then makes two dependent word reads: first the directory slot, whose frame field locates a second-level table, and then the slot in that table that describes the page.

At each level the walker checks the entry's valid and present flags. At the leaf it also checks the protection flags against the requested access. The walk ends with a one-cycle `done_o` pulse. That pulse carries either a frame number and permission set ready to be written into a translation cache, or a fault code that tells the handler why no translation exists.

Memory is reached through one read port. The request side uses a valid/ready handshake and the response side uses a single valid strobe with data, so any read latency is absorbed by waiting.

Top module: `tbl_walker`

## Requirements
- R1: The 32-bit virtual address splits into a 10-bit directory index [31:22], a 10-bit table index [21:12] and a 12-bit offset [11:0]. The first read goes to address `{dir_base_i, 12'h000} + 4*vaddr[31:22]`.
- R2: After a directory entry with valid and present set, the second read goes to `{entry[31:12], 12'h000} + 4*vaddr[21:12]`.
- R3: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays valid and its address does not change on the next cycle.
- R4: A successful walk makes exactly two reads. It ends with result code 0, `pfn_o` equal to leaf bits [31:12], and `prot_o` equal to leaf bits [4:2] (prot bit 0 read, bit 1 write, bit 2 execute).
- R5: If an entry at either level has valid (bit 0) clear, the walk ends with code 1 and issues no further read. Validity is checked before presence.
- R6: If an entry at either level has valid set and present (bit 1) clear, the walk ends with code 2 and issues no further read.
- R7: A leaf that is valid and present ends the walk with code 3 when any bit set in `acc_i` (bit 0 read, bit 1 write, bit 2 execute) is clear in its protection field. The protection bits of a directory entry are not checked.
- R8: `done_o` is high for exactly one cycle per walk, and the walker is idle in the next cycle. On any fault, `pfn_o` and `prot_o` are zero.
- R9: `busy_o` rises in the cycle after an accepted start and stays high through the done cycle. A `start_i` seen while `busy_o` is high is ignored.
- R10: The walker waits any number of cycles for `mem_rsp_valid_i` in each wait phase. A response is used only while a read is outstanding.
- R11: Reset is synchronous and active high. After it, the walker is idle, with no request and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| vaddr_i | input | 32 | Virtual address that missed |
| acc_i | input | 3 | Requested access: bit0 read, bit1 write, bit2 execute |
| dir_base_i | input | 20 | Frame number of the page directory |
| busy_o | output | 1 | Walk in progress |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 32 | Byte address of the word to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data (a table entry) |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 2 | 0 ok, 1 segmentation fault, 2 page fault, 3 protection fault |
| pfn_o | output | 20 | Translated frame number (zero on fault) |
| prot_o | output | 3 | Leaf permissions {X,W,R} (zero on fault) |

## Verification
The assertions assume a memory that returns exactly one response for each accepted request, never replies while no read is outstanding, and keeps `mem_rsp_data_i` meaningful only in the cycle it strobes `mem_rsp_valid_i`. The bench responder keeps to this. It queues each accepted address and answers it once, after zero to two idle cycles. It also drops `mem_req_ready_i` at random, so that request holding is exercised. Start pulses sent while the walker is busy are deliberately part of the stimulus, because the walker must ignore them.

// File: rtl/walk_pkg.sv
package walk_pkg;
    localparam int VA_W      = 32;
    localparam int OFF_W     = 12;
    localparam int IDX_W     = 10;
    localparam int ENT_SHIFT = 2;
    localparam int ACC_W     = 3;
    localparam int LEVELS    = 2;
    localparam int FRAME_W   = VA_W - OFF_W;
    localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_DIR, ST_WT_DIR, ST_RD_LEAF, ST_WT_LEAF, ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        RES_OK   = 2'd0,
        RES_SEGV = 2'd1,
        RES_PGF  = 2'd2,
        RES_PROT = 2'd3
    } walk_res_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [OFF_W-6:0]   spare;
        logic               x;
        logic               w;
        logic               r;
        logic               present;
        logic               valid;
    } entry_t;

    typedef struct packed {
        logic      stop;
        walk_res_e code;
    } verdict_t;

    function automatic logic [VA_W-1:0] slot_addr(input logic [FRAME_W-1:0] frame,
                                                  input logic [IDX_W-1:0]   idx);
        return {frame, {OFF_W{1'b0}}} + VA_W'({idx, {ENT_SHIFT{1'b0}}});
    endfunction

    function automatic logic [ACC_W-1:0] entry_perm(input entry_t e);
        return {e.x, e.w, e.r};
    endfunction
endpackage

// File: rtl/walk_addr.sv
module walk_addr
    import walk_pkg::*;
(
    input  logic [LEVELS-1:0][FRAME_W-1:0] base_i,
    input  logic [LEVELS-1:0][IDX_W-1:0]   idx_i,
    input  logic [LVL_W-1:0]               lvl_i,
    output logic [VA_W-1:0]                addr_o
);
    logic [LEVELS-1:0][VA_W-1:0] slot;

    // One slot-address adder per table level; the level counter picks one.
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign slot[g] = slot_addr(base_i[g], idx_i[g]);
    end

    assign addr_o = slot[lvl_i];
endmodule

// File: rtl/walk_eval.sv
module walk_eval
    import walk_pkg::*;
(
    input  entry_t           ent_i,
    input  logic             leaf_i,
    input  logic [ACC_W-1:0] acc_i,
    output verdict_t         verd_o
);
    always_comb begin
        verd_o.stop = 1'b1;
        verd_o.code = RES_OK;
        if (!ent_i.valid) begin
            verd_o.code = RES_SEGV;
        end else if (!ent_i.present) begin
            verd_o.code = RES_PGF;
        end else if (!leaf_i) begin
            verd_o.stop = 1'b0;
        end else if ((acc_i & ~entry_perm(ent_i)) != '0) begin
            verd_o.code = RES_PROT;
        end
    end
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
    import walk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [VA_W-1:0]    vaddr_i,
    input  logic [ACC_W-1:0]   acc_i,
    input  logic [FRAME_W-1:0] dir_base_i,
    input  logic               req_ready_i,
    input  logic               rsp_valid_i,
    input  entry_t             rsp_i,
    input  verdict_t           verd_i,
    output logic               busy_o,
    output logic               req_valid_o,
    output logic [LVL_W-1:0]   lvl_o,
    output logic [IDX_W-1:0]   dir_idx_o,
    output logic [IDX_W-1:0]   leaf_idx_o,
    output logic [FRAME_W-1:0] dir_frame_o,
    output logic [FRAME_W-1:0] leaf_frame_o,
    output logic [ACC_W-1:0]   acc_o,
    output logic               done_o,
    output walk_res_e          result_o,
    output logic [FRAME_W-1:0] pfn_o,
    output logic [ACC_W-1:0]   prot_o
);
    walk_state_e        state;
    logic [IDX_W-1:0]   dir_idx_q, leaf_idx_q;
    logic [FRAME_W-1:0] dir_q, leaf_q, pfn_q;
    logic [ACC_W-1:0]   acc_q, prot_q;
    walk_res_e          res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            dir_idx_q  <= '0;
            leaf_idx_q <= '0;
            dir_q      <= '0;
            leaf_q     <= '0;
            acc_q      <= '0;
            res_q      <= RES_OK;
            pfn_q      <= '0;
            prot_q     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start_i) begin
                    dir_idx_q  <= vaddr_i[VA_W-1 -: IDX_W];
                    leaf_idx_q <= vaddr_i[OFF_W +: IDX_W];
                    acc_q      <= acc_i;
                    dir_q      <= dir_base_i;
                    state      <= ST_RD_DIR;
                end
                ST_RD_DIR:  if (req_ready_i) state <= ST_WT_DIR;
                ST_WT_DIR:  if (rsp_valid_i) begin
                    if (verd_i.stop) begin
                        res_q  <= verd_i.code;
                        pfn_q  <= '0;
                        prot_q <= '0;
                        state  <= ST_DONE;
                    end else begin
                        leaf_q <= rsp_i.frame;
                        state  <= ST_RD_LEAF;
                    end
                end
                ST_RD_LEAF: if (req_ready_i) state <= ST_WT_LEAF;
                ST_WT_LEAF: if (rsp_valid_i) begin
                    res_q <= verd_i.code;
                    if (verd_i.code == RES_OK) begin
                        pfn_q  <= rsp_i.frame;
                        prot_q <= entry_perm(rsp_i);
                    end else begin
                        pfn_q  <= '0;
                        prot_q <= '0;
                    end
                    state <= ST_DONE;
                end
                ST_DONE:    state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o       = (state != ST_IDLE);
    assign req_valid_o  = (state == ST_RD_DIR) || (state == ST_RD_LEAF);
    assign lvl_o        = LVL_W'((state == ST_RD_LEAF) || (state == ST_WT_LEAF));
    assign dir_idx_o    = dir_idx_q;
    assign leaf_idx_o   = leaf_idx_q;
    assign dir_frame_o  = dir_q;
    assign leaf_frame_o = leaf_q;
    assign acc_o        = acc_q;
    assign done_o       = (state == ST_DONE);
    assign result_o     = res_q;
    assign pfn_o        = pfn_q;
    assign prot_o       = prot_q;

    // R11
    idle_after_reset_chk: assert property (@(posedge clk)
        rst |=> (!busy_o && !req_valid_o && !done_o));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));

    // R9
    start_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (busy_o && req_valid_o));

    // R8
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && result_o != RES_OK) |-> (pfn_o == '0 && prot_o == '0));

    // R5
    dir_segv_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WT_DIR && rsp_valid_i && !rsp_i.valid) |=>
        (done_o && result_o == RES_SEGV));

    // R10
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WT_LEAF && !rsp_valid_i) |=> (state == ST_WT_LEAF));
endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
    import walk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [VA_W-1:0]    vaddr_i,
    input  logic [ACC_W-1:0]   acc_i,
    input  logic [FRAME_W-1:0] dir_base_i,
    output logic               busy_o,
    output logic               mem_req_valid_o,
    input  logic               mem_req_ready_i,
    output logic [VA_W-1:0]    mem_req_addr_o,
    input  logic               mem_rsp_valid_i,
    input  logic [VA_W-1:0]    mem_rsp_data_i,
    output logic               done_o,
    output logic [1:0]         result_o,
    output logic [FRAME_W-1:0] pfn_o,
    output logic [ACC_W-1:0]   prot_o
);
    entry_t             rsp_ent;
    verdict_t           verd;
    walk_res_e          res;
    logic [LVL_W-1:0]   lvl;
    logic [IDX_W-1:0]   dir_idx, leaf_idx;
    logic [FRAME_W-1:0] dir_frame, leaf_frame;
    logic [ACC_W-1:0]   acc_held;

    assign rsp_ent  = entry_t'(mem_rsp_data_i);
    assign result_o = res;

    walk_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .vaddr_i      (vaddr_i),
        .acc_i        (acc_i),
        .dir_base_i   (dir_base_i),
        .req_ready_i  (mem_req_ready_i),
        .rsp_valid_i  (mem_rsp_valid_i),
        .rsp_i        (rsp_ent),
        .verd_i       (verd),
        .busy_o       (busy_o),
        .req_valid_o  (mem_req_valid_o),
        .lvl_o        (lvl),
        .dir_idx_o    (dir_idx),
        .leaf_idx_o   (leaf_idx),
        .dir_frame_o  (dir_frame),
        .leaf_frame_o (leaf_frame),
        .acc_o        (acc_held),
        .done_o       (done_o),
        .result_o     (res),
        .pfn_o        (pfn_o),
        .prot_o       (prot_o)
    );

    walk_eval u_eval (
        .ent_i  (rsp_ent),
        .leaf_i (lvl != '0),
        .acc_i  (acc_held),
        .verd_o (verd)
    );

    walk_addr u_addr (
        .base_i ({leaf_frame, dir_frame}),
        .idx_i  ({leaf_idx, dir_idx}),
        .lvl_i  (lvl),
        .addr_o (mem_req_addr_o)
    );

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid_o && !mem_req_ready_i) |=>
        (mem_req_valid_o && $stable(mem_req_addr_o)));

    // R4
    ok_walk_perm_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && result_o == 2'd0) |-> ((acc_held & ~prot_o) == '0));
endmodule

// File: tb/tbl_walker_bench.sv
module tbl_walker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] vaddr_i = '0;
    logic [2:0]  acc_i = '0;
    logic [19:0] dir_base_i = '0;
    logic        mem_req_ready_i = 1'b0;
    logic        mem_rsp_valid_i = 1'b0;
    logic [31:0] mem_rsp_data_i = '0;
    logic        busy_o, mem_req_valid_o, done_o;
    logic [31:0] mem_req_addr_o;
    logic [1:0]  result_o;
    logic [19:0] pfn_o;
    logic [2:0]  prot_o;

    always #4 clk = ~clk;

    tbl_walker u_tbl_walker (.*);

    localparam logic [19:0] BASE = 20'h00010;

    int n_cmp = 0;
    int n_bad = 0;
    int rd_count = 0;

    logic [31:0] mem [int unsigned];
    logic [31:0] pend_addr [$];
    int          pend_dly  [$];

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 dir read, 2 dir wait, 3 leaf read, 4 leaf wait, 5 done
    int          m_ph = 0;
    logic [31:0] m_va;
    logic [2:0]  m_acc;
    logic [19:0] m_base, m_tbase, m_pfn;
    logic [2:0]  m_prot;
    int          m_res;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0;
        end else begin
            case (m_ph)
                0: if (start_i) begin
                    m_va = vaddr_i; m_acc = acc_i; m_base = dir_base_i; m_ph = 1;
                end
                1: if (mem_req_ready_i) m_ph = 2;
                2: if (mem_rsp_valid_i) begin
                    m_pfn = 0; m_prot = 0;
                    if (!mem_rsp_data_i[0]) begin m_res = 1; m_ph = 5; end
                    else if (!mem_rsp_data_i[1]) begin m_res = 2; m_ph = 5; end
                    else begin m_tbase = mem_rsp_data_i[31:12]; m_ph = 3; end
                end
                3: if (mem_req_ready_i) m_ph = 4;
                4: if (mem_rsp_valid_i) begin
                    m_pfn = 0; m_prot = 0; m_ph = 5;
                    if (!mem_rsp_data_i[0]) m_res = 1;
                    else if (!mem_rsp_data_i[1]) m_res = 2;
                    else if ((m_acc & ~mem_rsp_data_i[4:2]) != 0) m_res = 3;
                    else begin
                        m_res = 0; m_pfn = mem_rsp_data_i[31:12]; m_prot = mem_rsp_data_i[4:2];
                    end
                end
                default: m_ph = 0;
            endcase
        end
    end

    // Per-cycle comparison, then memory responder
    always @(negedge clk) begin
        if (!rst) begin
            chk("R9", "busy", 32'(busy_o), 32'(m_ph != 0));
            chk("R3", "req_valid", 32'(mem_req_valid_o), 32'(m_ph == 1 || m_ph == 3));
            if (m_ph == 1)
                chk("R1", "dir addr", mem_req_addr_o, {m_base, 12'h0} + {20'h0, m_va[31:22], 2'b00});
            if (m_ph == 3)
                chk("R2", "leaf addr", mem_req_addr_o, {m_tbase, 12'h0} + {20'h0, m_va[21:12], 2'b00});
            chk("R8", "done", 32'(done_o), 32'(m_ph == 5));
            if (m_ph == 5) begin
                case (m_res)
                    0: chk("R4", "result", 32'(result_o), 32'(m_res));
                    1: chk("R5", "result", 32'(result_o), 32'(m_res));
                    2: chk("R6", "result", 32'(result_o), 32'(m_res));
                    default: chk("R7", "result", 32'(result_o), 32'(m_res));
                endcase
                chk("R8", "pfn", 32'(pfn_o), 32'(m_pfn));
                chk("R8", "prot", 32'(prot_o), 32'(m_prot));
            end
        end
        mem_rsp_valid_i = 1'b0;
        mem_rsp_data_i  = 32'hDEAD_BEEF;
        if (pend_addr.size() != 0) begin
            if (pend_dly[0] == 0) begin
                mem_rsp_valid_i = 1'b1;
                mem_rsp_data_i  = rd(pend_addr[0]);
                void'(pend_addr.pop_front());
                void'(pend_dly.pop_front());
            end else begin
                pend_dly[0] = pend_dly[0] - 1;
            end
        end
        mem_req_ready_i = ($urandom_range(3, 0) != 0);
        if (!rst && mem_req_valid_o && mem_req_ready_i) begin
            pend_addr.push_back(mem_req_addr_o);
            pend_dly.push_back(int'($urandom_range(2, 0)));
            rd_count++;
        end
    end

    task automatic ref_walk(input logic [31:0] va, input logic [2:0] acc,
                            output int res, output logic [19:0] pfn,
                            output logic [2:0] prot, output int reads);
        logic [31:0] d, l;
        pfn = 0; prot = 0; reads = 1;
        d = rd({BASE, 12'h0} + {20'h0, va[31:22], 2'b00});
        if (!d[0]) begin res = 1; return; end
        if (!d[1]) begin res = 2; return; end
        reads = 2;
        l = rd({d[31:12], 12'h0} + {20'h0, va[21:12], 2'b00});
        if (!l[0]) res = 1;
        else if (!l[1]) res = 2;
        else if ((acc & ~l[4:2]) != 0) res = 3;
        else begin res = 0; pfn = l[31:12]; prot = l[4:2]; end
    endtask

    task automatic do_walk(input logic [31:0] va, input logic [2:0] acc,
                           input string tag, input bit poke);
        int          e_res, e_reads, r0, guard;
        logic [19:0] e_pfn;
        logic [2:0]  e_prot;
        ref_walk(va, acc, e_res, e_pfn, e_prot, e_reads);
        @(negedge clk);
        vaddr_i = va; acc_i = acc; dir_base_i = BASE; start_i = 1'b1;
        r0 = rd_count;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            chk("R9", "busy after start", 32'(busy_o), 32'd1);
            vaddr_i = 32'hFFFF_FFFF; acc_i = 3'b111; start_i = 1'b1;
            @(negedge clk);
            @(negedge clk);
            start_i = 1'b0;
        end
        guard = 0;
        while (!done_o && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(tag, "walk result", 32'(result_o), 32'(e_res));
        chk(tag, "walk pfn", 32'(pfn_o), 32'(e_pfn));
        chk(tag, "walk prot", 32'(prot_o), 32'(e_prot));
        chk(tag, "read count", 32'(rd_count - r0), 32'(e_reads));
        @(negedge clk);
        chk("R8", "idle after done", {30'h0, busy_o, done_o}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // directory at 0x10000, tables at 0x20000 and 0x30000
        mem[32'h0001_0004] = {20'h00020, 12'h003};        // dir 1: valid+present
        mem[32'h0002_0008] = {20'hABCDE, 12'h00F};        // R,W
        mem[32'h0002_000C] = 32'h0;                        // invalid leaf
        mem[32'h0002_0010] = {20'h55555, 12'h01D};        // valid, not present
        mem[32'h0002_0014] = {20'h0F0F0, 12'h013};        // X only
        mem[32'h0001_0018] = {20'h00020, 12'h001};        // dir 6: valid, not present
        mem[32'h0001_001C] = {20'h00020, 12'h01E};        // dir 7: present, not valid
        mem[32'h0001_0FFC] = {20'h00030, 12'h003};        // dir 1023, no perms
        mem[32'h0003_0FFC] = {20'h12345, 12'h01F};        // R,W,X

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R11", "reset busy", 32'(busy_o), 32'd0);
        chk("R11", "reset req", 32'(mem_req_valid_o), 32'd0);
        chk("R11", "reset done", 32'(done_o), 32'd0);

        do_walk({10'd1, 10'd2, 12'h123}, 3'b001, "R4", 1'b0);    // read ok
        do_walk({10'd1, 10'd2, 12'h000}, 3'b011, "R4", 1'b0);    // read+write ok
        do_walk({10'd1, 10'd2, 12'hFFF}, 3'b100, "R7", 1'b0);    // exec denied
        do_walk({10'd5, 10'd0, 12'h000}, 3'b001, "R5", 1'b0);    // empty dir slot
        do_walk({10'd7, 10'd2, 12'h000}, 3'b001, "R5", 1'b0);    // present but invalid
        do_walk({10'd6, 10'd2, 12'h000}, 3'b001, "R6", 1'b0);    // dir not present
        do_walk({10'd1, 10'd3, 12'h000}, 3'b001, "R5", 1'b0);    // invalid leaf
        do_walk({10'd1, 10'd4, 12'h000}, 3'b001, "R6", 1'b0);    // leaf not present
        do_walk({10'd1, 10'd5, 12'h000}, 3'b010, "R7", 1'b0);    // write on exec-only
        do_walk({10'd1, 10'd5, 12'h000}, 3'b100, "R4", 1'b0);    // exec ok
        do_walk({10'd1023, 10'd1023, 12'hFFF}, 3'b111, "R2", 1'b0); // top slots
        do_walk({10'd1, 10'd2, 12'h000}, 3'b000, "R4", 1'b0);    // no access asked
        do_walk({10'd1, 10'd2, 12'h000}, 3'b001, "R9", 1'b1);    // start while busy
        for (int i = 0; i < 40; i++)
            do_walk({10'd1, 10'(2 + i % 4), 12'h0}, 3'(i % 8), "R10", 1'b0);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11", "reset again idle", {29'h0, busy_o, mem_req_valid_o, done_o}, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule